// File: doc/BRIEF.md
# Load-Use Interlock for a Five-Stage Pipeline

This block detects the one data dependency that result forwarding cannot hide in a five-stage in-order pipeline. The case is an instruction in decode that reads a register which a load, now in execute, has not yet brought back from memory. When it sees this case, the block holds the program counter and the fetch/decode register for one cycle. It also sends an all-zero control word into the execute stage, so that slot carries a no-op bubble. On the next cycle the load has moved on to memory access, and later forwarding supplies its data to the waiting instruction.

The detector is combinational. It looks at the decode-stage source indices and their "really read" flags, and at the execute-stage destination index and its memory-read control bit. A small set of pipeline registers is included around it: a PC register, a fetch/decode register, and a decode/execute register. With these, the held PC, the re-decoded instruction and the injected bubble can all be seen at the ports. Forwarding, branch resolution and the register file belong elsewhere.

Top module: `ldu_interlock`

## Requirements
- R1: After reset, `pc_q` is 0, `ex_rd` is 0, `ex_ctrl` is all zero, `de_use` is 0 and `stall` is low.
- R2: `stall` is high exactly when all three of these hold: bit 0 of `ex_ctrl` (the memory-read bit) is 1; `ex_rd` is nonzero; and at least one used decode source equals `ex_rd`. A control word without bit 0 never stalls.
- R3: When `ex_rd` is 0 (the constant-zero register), `stall` stays low whatever the sources are.
- R4: `de_use[0]` qualifies `de_rs1` and `de_use[1]` qualifies `de_rs2`. A source whose flag is 0 never causes a stall, even when its index equals `ex_rd`.
- R5: While `stall` is high, `pc_we` and `ifid_we` are 0 and `bubble_sel` is 1. While `stall` is low, `pc_we` and `ifid_we` are 1 and `bubble_sel` is 0.
- R6: In the cycle after a stall, `ex_ctrl` is all zero and `ex_rd` is 0.
- R7: In the cycle after a stall, `pc_q`, `de_rs1`, `de_rs2` and `de_use` hold the values they had during the stall. The fetch inputs presented during the stall are dropped.
- R8: One load followed by one dependent instruction gives exactly one stall cycle. `stall` is never high on two consecutive cycles.
- R9: In a cycle without a stall, three things happen at the clock edge: `pc_q` loads `pc_next`; the decode fields load the fetch inputs; and `ex_rd`/`ex_ctrl` load the decode instruction's destination and control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_next | input | AW | Next program counter candidate |
| fe_rs1 | input | RW | Fetched instruction, first source index |
| fe_rs2 | input | RW | Fetched instruction, second source index |
| fe_rd | input | RW | Fetched instruction, destination index |
| fe_use | input | 2 | Source-read flags: bit 0 for rs1, bit 1 for rs2 |
| fe_ctrl | input | CW | Fetched instruction control word, bit 0 is memory read |
| pc_q | output | AW | Program counter register |
| de_rs1 | output | RW | Decode-stage first source index |
| de_rs2 | output | RW | Decode-stage second source index |
| de_use | output | 2 | Decode-stage source-read flags |
| ex_rd | output | RW | Execute-stage destination index |
| ex_ctrl | output | CW | Execute-stage control word |
| stall | output | 1 | Load-use hazard detected this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| bubble_sel | output | 1 | Selects the zero control word into execute |

## Verification
The hardest situation to reach from the ports is a load sitting in execute at the same time as a chosen consumer sits in decode. That takes a load fed one cycle ahead of the consumer, and it has to hold for every pairing of destination, source indices and read flags. The bench issues a load, then the consumer, then fillers. It sweeps every destination index against every first-source index and every flag combination, with a second source derived from the first. A second sweep uses a control word without the memory-read bit. A reference pipeline kept in the bench predicts the stall, the held state and the bubble on each cycle.

// File: rtl/ldu_pkg.sv
package ldu_pkg;

  // Widest register index the helper functions accept.
  localparam int unsigned IDX_MAX = 8;

  // A source hits when it is read, the destination is not the zero register,
  // and the indices agree.
  function automatic logic src_hit(input logic used,
                                   input logic [IDX_MAX-1:0] src,
                                   input logic [IDX_MAX-1:0] dst);
    return used && (dst != '0) && (src == dst);
  endfunction

  // Interlock decision from the load flag and the per-source hits.
  function automatic logic need_stall(input logic load_in_ex,
                                      input logic any_hit);
    return load_in_ex & any_hit;
  endfunction

endpackage

// File: rtl/ldu_src_cmp.sv
module ldu_src_cmp #(
  parameter int unsigned RW = 5
) (
  input  logic          used,
  input  logic [RW-1:0] src,
  input  logic [RW-1:0] dst,
  output logic          hit
);
  import ldu_pkg::*;

  localparam int unsigned PADW = IDX_MAX;

  logic [PADW-1:0] src_w;
  logic [PADW-1:0] dst_w;

  assign src_w = PADW'(src);
  assign dst_w = PADW'(dst);
  assign hit   = src_hit(used, src_w, dst_w);

endmodule

// File: rtl/ldu_detect.sv
module ldu_detect #(
  parameter int unsigned RW      = 5,
  parameter int unsigned CW      = 4,
  parameter int unsigned NSRC    = 2,
  parameter int unsigned MRD_BIT = 0
) (
  input  logic [NSRC*RW-1:0] srcs,
  input  logic [NSRC-1:0]    used,
  input  logic [RW-1:0]      ex_rd,
  input  logic [CW-1:0]      ex_ctrl,
  output logic [NSRC-1:0]    hits,
  output logic               load_in_ex,
  output logic               stall
);
  import ldu_pkg::*;

  // One comparator per source operand.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ldu_src_cmp #(.RW(RW)) u_cmp (
      .used (used[g]),
      .src  (srcs[g*RW +: RW]),
      .dst  (ex_rd),
      .hit  (hits[g])
    );
  end

  assign load_in_ex = ex_ctrl[MRD_BIT];
  assign stall      = need_stall(load_in_ex, |hits);

endmodule

// File: rtl/ldu_pipe_regs.sv
module ldu_pipe_regs #(
  parameter int unsigned AW = 32,
  parameter int unsigned RW = 5,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_we,
  input  logic          ifid_we,
  input  logic          bubble_sel,
  input  logic [AW-1:0] pc_next,
  input  logic [RW-1:0] fe_rs1,
  input  logic [RW-1:0] fe_rs2,
  input  logic [RW-1:0] fe_rd,
  input  logic [1:0]    fe_use,
  input  logic [CW-1:0] fe_ctrl,
  output logic [AW-1:0] pc_q,
  output logic [RW-1:0] de_rs1,
  output logic [RW-1:0] de_rs2,
  output logic [RW-1:0] de_rd,
  output logic [1:0]    de_use,
  output logic [CW-1:0] de_ctrl,
  output logic [RW-1:0] ex_rd,
  output logic [CW-1:0] ex_ctrl
);

  // Program counter
  always_ff @(posedge clk) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_we) pc_q <= pc_next;
  end

  // Fetch/decode register; reset leaves a no-op that reads nothing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_rs1  <= '0;
      de_rs2  <= '0;
      de_rd   <= '0;
      de_use  <= '0;
      de_ctrl <= '0;
    end else if (ifid_we) begin
      de_rs1  <= fe_rs1;
      de_rs2  <= fe_rs2;
      de_rd   <= fe_rd;
      de_use  <= fe_use;
      de_ctrl <= fe_ctrl;
    end
  end

  // Decode/execute register; a bubble clears the control word and destination
  always_ff @(posedge clk) begin
    if (!rst_n || bubble_sel) begin
      ex_rd   <= '0;
      ex_ctrl <= '0;
    end else begin
      ex_rd   <= de_rd;
      ex_ctrl <= de_ctrl;
    end
  end

endmodule

// File: rtl/ldu_interlock.sv
module ldu_interlock #(
  parameter int unsigned AW      = 32,
  parameter int unsigned RW      = 5,
  parameter int unsigned CW      = 4,
  parameter int unsigned MRD_BIT = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc_next,
  input  logic [RW-1:0] fe_rs1,
  input  logic [RW-1:0] fe_rs2,
  input  logic [RW-1:0] fe_rd,
  input  logic [1:0]    fe_use,
  input  logic [CW-1:0] fe_ctrl,
  output logic [AW-1:0] pc_q,
  output logic [RW-1:0] de_rs1,
  output logic [RW-1:0] de_rs2,
  output logic [1:0]    de_use,
  output logic [RW-1:0] ex_rd,
  output logic [CW-1:0] ex_ctrl,
  output logic          stall,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          bubble_sel
);

  localparam int unsigned NSRC = 2;

  logic [RW-1:0]   de_rd;
  logic [CW-1:0]   de_ctrl;
  logic [NSRC-1:0] src_hit_w;
  logic            load_in_ex_w;

  ldu_detect #(.RW(RW), .CW(CW), .NSRC(NSRC), .MRD_BIT(MRD_BIT)) u_det (
    .srcs       ({de_rs2, de_rs1}),
    .used       (de_use),
    .ex_rd      (ex_rd),
    .ex_ctrl    (ex_ctrl),
    .hits       (src_hit_w),
    .load_in_ex (load_in_ex_w),
    .stall      (stall)
  );

  // Freeze the front end and inject a bubble while the hazard is present.
  assign pc_we      = ~stall;
  assign ifid_we    = ~stall;
  assign bubble_sel = stall;

  ldu_pipe_regs #(.AW(AW), .RW(RW), .CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_we      (pc_we),
    .ifid_we    (ifid_we),
    .bubble_sel (bubble_sel),
    .pc_next    (pc_next),
    .fe_rs1     (fe_rs1),
    .fe_rs2     (fe_rs2),
    .fe_rd      (fe_rd),
    .fe_use     (fe_use),
    .fe_ctrl    (fe_ctrl),
    .pc_q       (pc_q),
    .de_rs1     (de_rs1),
    .de_rs2     (de_rs2),
    .de_rd      (de_rd),
    .de_use     (de_use),
    .de_ctrl    (de_ctrl),
    .ex_rd      (ex_rd),
    .ex_ctrl    (ex_ctrl)
  );

endmodule

// File: rtl/ldu_interlock_chk.sv
module ldu_interlock_chk #(
  parameter int unsigned AW      = 32,
  parameter int unsigned RW      = 5,
  parameter int unsigned CW      = 4,
  parameter int unsigned MRD_BIT = 0
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] pc_next,
  input logic [AW-1:0] pc_q,
  input logic [RW-1:0] de_rs1,
  input logic [RW-1:0] de_rs2,
  input logic [1:0]    de_use,
  input logic [RW-1:0] ex_rd,
  input logic [CW-1:0] ex_ctrl,
  input logic          stall,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          bubble_sel,
  input logic [1:0]    src_hit_w,
  input logic          load_in_ex_w
);

  // R2
  need_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ex_ctrl[MRD_BIT] |-> !stall);

  // R2
  need_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_in_ex_w && src_hit_w != 2'b00) |-> stall);

  // R3
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_rd == '0) |-> !stall);

  // R4
  unused_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_use == 2'b00) |-> !stall);

  // R5
  freeze_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!pc_we && !ifid_we && bubble_sel));

  // R5
  run_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |-> (pc_we && ifid_we && !bubble_sel));

  // R6
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (ex_ctrl == '0 && ex_rd == '0));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && $stable(de_rs1) && $stable(de_rs2) && $stable(de_use)));

  // R8
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R9
  pc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc_q == $past(pc_next)));

endmodule

bind ldu_interlock ldu_interlock_chk #(.AW(AW), .RW(RW), .CW(CW), .MRD_BIT(MRD_BIT)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pc_next      (pc_next),
  .pc_q         (pc_q),
  .de_rs1       (de_rs1),
  .de_rs2       (de_rs2),
  .de_use       (de_use),
  .ex_rd        (ex_rd),
  .ex_ctrl      (ex_ctrl),
  .stall        (stall),
  .pc_we        (pc_we),
  .ifid_we      (ifid_we),
  .bubble_sel   (bubble_sel),
  .src_hit_w    (src_hit_w),
  .load_in_ex_w (load_in_ex_w)
);

// File: tb/sim_ldu_interlock.sv
`timescale 1ns/1ps
module sim_ldu_interlock;

  localparam int AW = 32;
  localparam int RW = 5;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] pc_next = '0;
  logic [RW-1:0] fe_rs1 = '0, fe_rs2 = '0, fe_rd = '0;
  logic [1:0]    fe_use = '0;
  logic [CW-1:0] fe_ctrl = '0;
  logic [AW-1:0] pc_q;
  logic [RW-1:0] de_rs1, de_rs2, ex_rd;
  logic [1:0]    de_use;
  logic [CW-1:0] ex_ctrl;
  logic          stall, pc_we, ifid_we, bubble_sel;

  always #10 clk = ~clk;  // 50 MHz

  ldu_interlock #(.AW(AW), .RW(RW), .CW(CW), .MRD_BIT(0)) u0 (
    .clk(clk), .rst_n(rst_n), .pc_next(pc_next),
    .fe_rs1(fe_rs1), .fe_rs2(fe_rs2), .fe_rd(fe_rd), .fe_use(fe_use), .fe_ctrl(fe_ctrl),
    .pc_q(pc_q), .de_rs1(de_rs1), .de_rs2(de_rs2), .de_use(de_use),
    .ex_rd(ex_rd), .ex_ctrl(ex_ctrl), .stall(stall),
    .pc_we(pc_we), .ifid_we(ifid_we), .bubble_sel(bubble_sel)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference pipeline state
  logic [AW-1:0] m_pc = '0;
  logic [RW-1:0] m_drs1 = '0, m_drs2 = '0, m_drd = '0, m_exrd = '0;
  logic [1:0]    m_duse = '0;
  logic [CW-1:0] m_dctrl = '0, m_exctrl = '0;
  logic          prev_stall = 1'b0;
  logic [AW-1:0] pc_count = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit exp_stall();
    bit m1, m2;
    m1 = m_duse[0] && ((m_drs1 ^ m_exrd) == 0);
    m2 = m_duse[1] && ((m_drs2 ^ m_exrd) == 0);
    return (m_exctrl[0] == 1'b1) && (m_exrd != 0) && (m1 || m2);
  endfunction

  function automatic string stall_tag();
    if (m_exrd == 0) return "R3";
    if (((m_drs1 == m_exrd) && !m_duse[0]) || ((m_drs2 == m_exrd) && !m_duse[1])) return "R4";
    return "R2";
  endfunction

  // Called away from the clock edge: compare, drive, advance one cycle.
  task automatic step(input logic [RW-1:0] rs1, input logic [RW-1:0] rs2,
                      input logic [RW-1:0] rd, input logic [1:0] u,
                      input logic [CW-1:0] c);
    bit es;
    es = exp_stall();
    chk(stall == es, stall_tag(), "stall", stall, es);
    chk(pc_we == !es && ifid_we == !es && bubble_sel == es, "R5", "controls",
        {pc_we, ifid_we, bubble_sel}, {!es, !es, es});
    chk(pc_q == m_pc, es ? "R7" : "R9", "pc_q", pc_q, m_pc);
    chk(de_rs1 == m_drs1 && de_rs2 == m_drs2 && de_use == m_duse, es ? "R7" : "R9",
        "decode fields", {de_rs1, de_rs2, de_use}, {m_drs1, m_drs2, m_duse});
    chk(ex_rd == m_exrd && ex_ctrl == m_exctrl, prev_stall ? "R6" : "R9",
        "exec fields", {ex_rd, ex_ctrl}, {m_exrd, m_exctrl});
    chk(!(prev_stall && stall), "R8", "consecutive stall", stall, 0);
    prev_stall = stall;
    pc_count += 4;
    pc_next = pc_count;
    fe_rs1 = rs1; fe_rs2 = rs2; fe_rd = rd; fe_use = u; fe_ctrl = c;
    @(posedge clk);
    if (es) begin
      m_exrd = '0; m_exctrl = '0;
    end else begin
      m_exrd = m_drd; m_exctrl = m_dctrl;
      m_drs1 = rs1; m_drs2 = rs2; m_drd = rd; m_duse = u; m_dctrl = c;
      m_pc = pc_count;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(pc_q == 0 && ex_rd == 0 && ex_ctrl == 0 && de_use == 0 && !stall, "R1",
        "reset state", {pc_q, ex_rd, ex_ctrl, de_use, stall}, 0);

    // Load (ctrl bit 0) then consumer, for every destination/source/flag combination
    for (int d = 0; d < 32; d++) begin
      for (int a = 0; a < 32; a++) begin
        for (int u = 0; u < 4; u++) begin
          step(5'(a ^ 9), 5'(d + 1), 5'(d), 2'b11, 4'b0011);
          step(5'(a), 5'((a * 7 + 3 + d) % 32), 5'(a ^ 5), 2'(u), 4'b0110);
          step(5'(0), 5'(0), 5'(0), 2'b00, 4'b0000);
          step(5'(0), 5'(0), 5'(0), 2'b00, 4'b0000);
        end
      end
    end

    // Non-load producer: control word without the memory-read bit never stalls (R2)
    for (int d = 0; d < 32; d++) begin
      for (int a = 0; a < 32; a++) begin
        step(5'(0), 5'(0), 5'(d), 2'b00, 4'b1110);
        step(5'(a), 5'(d), 5'(1), 2'b11, 4'b0010);
        step(5'(0), 5'(0), 5'(0), 2'b00, 4'b0000);
      end
    end

    // Chain of dependent loads back to back (R8, R6, R7)
    for (int k = 1; k < 32; k++) begin
      step(5'(k - 1), 5'(0), 5'(k), 2'b01, 4'b0001);
    end
    repeat (4) step(5'(0), 5'(0), 5'(0), 2'b00, 4'b0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule